// File: doc/BRIEF.md
# Shared Modular Exponentiation Engine

This block raises a 16-bit operand to a stored exponent and reduces the result modulo a stored modulus, for public-key style encryption and decryption on small keys. A single datapath serves both directions. A mode bit chooses which of two exponent registers is applied: the public exponent turns a message into a ciphertext, and the private exponent turns a ciphertext back into the message. Both directions share one modulus register.

Software or a neighbouring block fills the key registers through a small write port. It then pulses start with the operand and the mode. The engine copies the operand and the selected key at start, so key writes made during a run cannot disturb it. The exponent is walked from its most significant bit down. Every bit costs one modular squaring, and a set bit adds one modular multiplication by the operand. Each modular product is formed at full 32-bit width and reduced by a sequential shift-subtract remainder unit. An operand that is not smaller than the modulus is refused: the engine reports it invalid at once and computes nothing. A one-cycle done strobe marks each result.

Top module: `modexp_engine`

## Requirements
- R1: With mode = 0 the result equals din^E mod N, where E is the public exponent register. With N = 33 and E = 7, input 2 yields 29.
- R2: With mode = 1 the result equals din^D mod N, where D is the private exponent register. With N = 33 and D = 3, input 29 yields 2.
- R3: When key_we is high, key_data is written to the register chosen by key_sel: 0 selects the modulus N, 1 the public exponent E, 2 the private exponent D. key_sel = 3 writes nothing.
- R4: If din >= N at start, the engine raises done together with invalid = 1 and result = 0, and does not compute.
- R5: An exponent of zero yields result 1 for any valid input when N > 1.
- R6: done is high for exactly one cycle per accepted request. result and invalid hold their value until the next done.
- R7: A start pulse that arrives while a computation is in progress is ignored and produces no extra done.
- R8: For every accepted valid request the result is below N and equals the exact modular power. This covers the moduli 33, 65521 and 65535, the operand 0 and the operand N - 1.
- R9: After synchronous reset done = 0, invalid = 0 and result = 0, and all key registers read as zero.
- R10: The operand, exponent and modulus are captured at start. Key writes during a run affect only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_we | input | 1 | Key register write enable |
| key_sel | input | 2 | Key register select (0 modulus, 1 public exponent, 2 private exponent) |
| key_data | input | 16 | Key register write data |
| start | input | 1 | Request pulse, accepted only when idle |
| mode | input | 1 | 0 = encrypt with public exponent, 1 = decrypt with private exponent |
| din | input | 16 | Message or ciphertext operand |
| result | output | 16 | Registered modular power |
| done | output | 1 | One-cycle completion strobe |
| invalid | output | 1 | Set with done when the operand was not below the modulus |

## Verification
The hardest conditions to reach from the ports are the ones that arise in the middle of a run, long after start: a second start pulse, and a key write that lands while the engine is busy. The stimulus reaches them by issuing a request and waiting a fixed number of cycles, well inside the run of roughly a thousand cycles. It then pulses start again with a different operand, or rewrites the public exponent. After the scoreboard drains, the bench keeps watching for longer than a full run to confirm that no second done appears. A following request then shows that the rewritten exponent takes effect only from there on. The operand boundary is covered by requests at N - 1, at N and above N. The modulus range is covered by keys close to 2^16.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

  // key register select codes used by the write port
  typedef enum logic [1:0] {
    KSEL_MOD  = 2'd0,
    KSEL_PUB  = 2'd1,
    KSEL_PRIV = 2'd2,
    KSEL_NONE = 2'd3
  } ksel_e;

  localparam int unsigned KEY_SLOTS = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SQR,
    ST_SQR_WAIT,
    ST_MUL,
    ST_MUL_WAIT,
    ST_NEXT,
    ST_FIN
  } state_e;

endpackage

// File: rtl/modexp_keyregs.sv
module modexp_keyregs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [1:0]   sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] key_n,
  output logic [W-1:0] key_e,
  output logic [W-1:0] key_d
);
  import modexp_pkg::*;

  logic [W-1:0] slot [KEY_SLOTS];

  for (genvar g = 0; g < KEY_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot[g] <= '0;
      end else if (we && (sel == 2'(g))) begin
        slot[g] <= wdata;
      end
    end
  end

  assign key_n = slot[KSEL_MOD];
  assign key_e = slot[KSEL_PUB];
  assign key_d = slot[KSEL_PRIV];

endmodule

// File: rtl/modexp_modred.sv
module modexp_modred #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   modulus,
  output logic           done,
  output logic [W-1:0]   rem
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(PW + 1);

  logic [PW-1:0] sh_q;
  logic [W-1:0]  part_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    trial;
  logic [W:0]    nxt;
  logic          ge;

  always_comb begin
    trial = {part_q, sh_q[PW-1]};
    ge    = trial >= {1'b0, modulus};
    nxt   = ge ? (trial - {1'b0, modulus}) : trial;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      part_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        sh_q   <= dividend;
        part_q <= '0;
        cnt_q  <= CW'(PW);
        run_q  <= 1'b1;
      end else if (run_q) begin
        sh_q   <= sh_q << 1;
        part_q <= nxt[W-1:0];
        cnt_q  <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign rem = part_q;

endmodule

// File: rtl/modexp_ctrl.sv
module modexp_ctrl #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           mode,
  input  logic [W-1:0]   din,
  input  logic [W-1:0]   key_n,
  input  logic [W-1:0]   key_e,
  input  logic [W-1:0]   key_d,
  output logic           red_go,
  output logic [2*W-1:0] red_prod,
  output logic [W-1:0]   red_mod,
  input  logic           red_done,
  input  logic [W-1:0]   red_rem,
  output logic [W-1:0]   result,
  output logic           done,
  output logic           invalid
);
  import modexp_pkg::*;

  localparam int PW = 2 * W;
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  state_e        st_q;
  logic [W-1:0]  base_q;
  logic [W-1:0]  exp_q;
  logic [W-1:0]  mod_q;
  logic [W-1:0]  acc_q;
  logic [IW-1:0] idx_q;
  logic          inv_q;
  logic [PW-1:0] acc_ext;
  logic [PW-1:0] base_ext;

  assign acc_ext  = {{W{1'b0}}, acc_q};
  assign base_ext = {{W{1'b0}}, base_q};
  assign red_mod  = mod_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      base_q   <= '0;
      exp_q    <= '0;
      mod_q    <= '0;
      acc_q    <= '0;
      idx_q    <= '0;
      inv_q    <= 1'b0;
      red_go   <= 1'b0;
      red_prod <= '0;
      result   <= '0;
      done     <= 1'b0;
      invalid  <= 1'b0;
    end else begin
      red_go <= 1'b0;
      done   <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            base_q <= din;
            exp_q  <= mode ? key_d : key_e;
            mod_q  <= key_n;
            idx_q  <= IW'(W - 1);
            if (din >= key_n) begin
              inv_q <= 1'b1;
              acc_q <= '0;
              st_q  <= ST_FIN;
            end else begin
              inv_q <= 1'b0;
              acc_q <= (key_n == W'(1)) ? '0 : W'(1);
              st_q  <= ST_SQR;
            end
          end
        end
        ST_SQR: begin
          red_go   <= 1'b1;
          red_prod <= acc_ext * acc_ext;
          st_q     <= ST_SQR_WAIT;
        end
        ST_SQR_WAIT: begin
          if (red_done) begin
            acc_q <= red_rem;
            st_q  <= exp_q[idx_q] ? ST_MUL : ST_NEXT;
          end
        end
        ST_MUL: begin
          red_go   <= 1'b1;
          red_prod <= acc_ext * base_ext;
          st_q     <= ST_MUL_WAIT;
        end
        ST_MUL_WAIT: begin
          if (red_done) begin
            acc_q <= red_rem;
            st_q  <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (idx_q == '0) begin
            st_q <= ST_FIN;
          end else begin
            idx_q <= idx_q - IW'(1);
            st_q  <= ST_SQR;
          end
        end
        ST_FIN: begin
          result  <= acc_q;
          invalid <= inv_q;
          done    <= 1'b1;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/modexp_engine.sv
module modexp_engine #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         key_we,
  input  logic [1:0]   key_sel,
  input  logic [W-1:0] key_data,
  input  logic         start,
  input  logic         mode,
  input  logic [W-1:0] din,
  output logic [W-1:0] result,
  output logic         done,
  output logic         invalid
);
  logic [W-1:0]   key_n;
  logic [W-1:0]   key_e;
  logic [W-1:0]   key_d;
  logic           red_go;
  logic [2*W-1:0] red_prod;
  logic [W-1:0]   red_mod;
  logic           red_done;
  logic [W-1:0]   red_rem;

  modexp_keyregs #(.W(W)) u_keys (
    .clk   (clk),
    .rst   (rst),
    .we    (key_we),
    .sel   (key_sel),
    .wdata (key_data),
    .key_n (key_n),
    .key_e (key_e),
    .key_d (key_d)
  );

  modexp_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mode     (mode),
    .din      (din),
    .key_n    (key_n),
    .key_e    (key_e),
    .key_d    (key_d),
    .red_go   (red_go),
    .red_prod (red_prod),
    .red_mod  (red_mod),
    .red_done (red_done),
    .red_rem  (red_rem),
    .result   (result),
    .done     (done),
    .invalid  (invalid)
  );

  modexp_modred #(.W(W)) u_red (
    .clk      (clk),
    .rst      (rst),
    .go       (red_go),
    .dividend (red_prod),
    .modulus  (red_mod),
    .done     (red_done),
    .rem      (red_rem)
  );

endmodule

// File: rtl/modexp_engine_chk.sv
module modexp_engine_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         done,
  input logic         invalid,
  input logic [W-1:0] result,
  input logic         red_done,
  input logic [W-1:0] red_rem,
  input logic [W-1:0] red_mod
);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(result) && $stable(invalid)));

  // R4
  invalid_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    invalid |-> done || $stable(invalid));

  // R4
  reject_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && invalid) |-> (result == '0));

  // R8
  result_below_mod_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !invalid) |-> (result < red_mod));

  // R8
  rem_below_mod_chk: assert property (@(posedge clk) disable iff (rst)
    red_done |-> (red_rem < red_mod));

endmodule

bind modexp_engine modexp_engine_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .done     (done),
  .invalid  (invalid),
  .result   (result),
  .red_done (red_done),
  .red_rem  (red_rem),
  .red_mod  (red_mod)
);

// File: tb/test_modexp_engine.sv
`timescale 1ns/1ps
module test_modexp_engine;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         key_we = 1'b0;
  logic [1:0]   key_sel = '0;
  logic [W-1:0] key_data = '0;
  logic         start = 1'b0;
  logic         mode = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] result;
  logic         done;
  logic         invalid;

  int checks = 0;
  int failures = 0;
  int unexpected = 0;
  logic prev_done = 1'b0;

  logic [W:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  modexp_engine #(.W(W)) i_modexp_engine (
    .clk(clk), .rst(rst), .key_we(key_we), .key_sel(key_sel),
    .key_data(key_data), .start(start), .mode(mode), .din(din),
    .result(result), .done(done), .invalid(invalid)
  );

  function automatic logic [W-1:0] ref_pow(longint b, longint e, longint n);
    longint r, bb, ee;
    r = 1 % n;
    bb = b % n;
    ee = e;
    while (ee != 0) begin
      if (ee[0]) r = (r * bb) % n;
      bb = (bb * bb) % n;
      ee = ee >> 1;
    end
    return W'(r);
  endfunction

  task automatic check(string tag, longint act, longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every done
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prev_done) check("R6 done longer than one cycle", 1, 0);
      if (done) begin
        if (exp_q.size() == 0) begin
          unexpected++;
          check("R7 unexpected done", 1, 0);
        end else begin
          logic [W:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " invalid"}, invalid, e[W]);
          check({t, " result"}, result, e[W-1:0]);
        end
      end
      prev_done = done;
    end
  end

  task automatic write_key(logic [1:0] s, logic [W-1:0] v);
    @(negedge clk);
    key_we = 1'b1; key_sel = s; key_data = v;
    @(negedge clk);
    key_we = 1'b0;
  endtask

  task automatic issue(logic m, logic [W-1:0] x, logic inv, logic [W-1:0] r, string tag);
    exp_q.push_back({inv, r});
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b1; mode = m; din = x;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run(logic m, logic [W-1:0] x, logic inv, logic [W-1:0] r, string tag);
    issue(m, x, inv, r, tag);
    drain();
  endtask

  initial begin
    repeat (20000 * 8) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R9 reset state
    check("R9 done", done, 0);
    check("R9 invalid", invalid, 0);
    check("R9 result", result, 0);
    @(negedge clk);
    rst = 1'b0;
    // R9 key registers zero: N = 0 makes every operand invalid
    run(1'b0, 16'd0, 1'b1, 16'd0, "R9 zero modulus after reset");

    write_key(2'd0, 16'd33);
    write_key(2'd1, 16'd7);
    write_key(2'd2, 16'd3);
    run(1'b0, 16'd2, 1'b0, 16'd29, "R1 encrypt 2");
    check("R6 result held", result, 29);
    repeat (20) @(negedge clk);
    check("R6 result held after idle", result, 29);
    run(1'b1, 16'd29, 1'b0, 16'd2, "R2 decrypt 29");
    run(1'b0, 16'd5, 1'b0, ref_pow(5, 7, 33), "R1 encrypt 5");
    run(1'b1, ref_pow(5, 7, 33), 1'b0, 16'd5, "R2 decrypt back to 5");

    // R4 boundary
    run(1'b0, 16'd33, 1'b1, 16'd0, "R4 operand equal N");
    run(1'b1, 16'd40, 1'b1, 16'd0, "R4 operand above N");
    run(1'b0, 16'd32, 1'b0, 16'd32, "R8 operand N-1");
    run(1'b0, 16'd0, 1'b0, 16'd0, "R8 operand zero");

    // R5 zero exponent
    write_key(2'd1, 16'd0);
    run(1'b0, 16'd5, 1'b0, 16'd1, "R5 zero exponent");

    // R3 select 3 writes nothing
    write_key(2'd1, 16'd7);
    write_key(2'd3, 16'd1234);
    run(1'b0, 16'd2, 1'b0, 16'd29, "R3 sel3 keeps E");
    run(1'b1, 16'd29, 1'b0, 16'd2, "R3 sel3 keeps D");
    run(1'b0, 16'd33, 1'b1, 16'd0, "R3 sel3 keeps N");

    // R10 key write during a run
    issue(1'b0, 16'd2, 1'b0, 16'd29, "R10 run with old E");
    repeat (50) @(negedge clk);
    write_key(2'd1, 16'd3);
    drain();
    run(1'b0, 16'd2, 1'b0, 16'd8, "R10 new E used next");

    // R7 start while busy
    issue(1'b0, 16'd4, 1'b0, ref_pow(4, 3, 33), "R7 first request");
    repeat (30) @(negedge clk);
    @(negedge clk);
    start = 1'b1; mode = 1'b1; din = 16'd10;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (1500) @(negedge clk);
    check("R7 no extra done", unexpected, 0);

    // R8 large moduli
    write_key(2'd0, 16'd65521);
    write_key(2'd1, 16'd257);
    write_key(2'd2, 16'd40000);
    run(1'b0, 16'd65520, 1'b0, ref_pow(65520, 257, 65521), "R8 N-1 big modulus");
    run(1'b1, 16'd12345, 1'b0, ref_pow(12345, 40000, 65521), "R8 decrypt big");
    run(1'b0, 16'd65521, 1'b1, 16'd0, "R4 big operand equal N");
    write_key(2'd0, 16'd65535);
    write_key(2'd1, 16'd65535);
    run(1'b0, 16'd65534, 1'b0, ref_pow(65534, 65535, 65535), "R8 all-ones exponent");
    run(1'b0, 16'd4097, 1'b0, ref_pow(4097, 65535, 65535), "R8 pattern 4097");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule